// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the clocked read front end of a memory device. A host first writes a small configuration word that turns burst reads on, picks the clock edge the sequencer acts on, and sets the first-access latency. With burst reads on, one clock with the address strobe low captures a start address. After the programmed number of active edges the block starts sending array words, one per active edge, from consecutive addresses. A data-valid flag marks each clock that carries a burst word.

The configuration resets to burst-off. In that state the address strobe still latches an address, but the array word is sent to the output combinationally and no clocked sequencing takes place. Chip enable ends any burst and blanks the output. Output enable only gates the pins: a burst keeps counting while the output is gated off.

The sequencer exists twice, once for each clock edge, and the edge field chooses which copy runs. The array is outside the block. It is reached through a combinational read port: the block drives an address out and receives the data word back.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset the configuration holds burst-off. The address counter is zero and `dout_valid` is low, so with `ce_n` and `oe_n` low `dout` shows the array word at address 0. A write with `cfg_we` high is taken on the rising clock edge. The configuration word has burst enable at bit 0, falling-edge select at bit 1 and latency at bits 5:2.
- R2: In burst mode, an active edge with `adv_n` low loads `addr_in` into the address counter, and the first burst word is the array word at that address.
- R3: After the loading edge, `dout_valid` stays low and `dout` reads zero until the L-th active edge after it, where L is the latency. After that edge the first word is valid.
- R4: Latency field values 0 and 1 act as 2. Values from 2 to 15 are used as given.
- R5: After the first word, each active edge presents the word at the next address, one higher than the last. The address wraps from all-ones to zero. `dout_valid` is high on every clock that carries a word.
- R6: With the edge-select bit set, capture, latency counting and word stepping happen on falling clock edges.
- R7: With burst off, an edge with `adv_n` low latches the address. `dout` then follows the array word at the latched address combinationally, and `dout_valid` stays low.
- R8: An `adv_n` low edge during a wait or data phase abandons that burst. Output goes invalid and a new burst starts from the new address with the full latency.
- R9: With `ce_n` high at an active edge, the burst ends, `dout` is zero and `dout_valid` is low. No burst resumes until a new address strobe.
- R10: While `oe_n` is high, `dout` is zero and `dout_valid` is low, but the address counter keeps stepping. When `oe_n` goes low again the word for the current position is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe (rising edge) |
| cfg_wdata | input | LAT_W+2 | Configuration word: [0] burst on, [1] falling edge, [LAT_W+1:2] latency |
| adv_n | input | 1 | Active-low address strobe |
| addr_in | input | AW | Start address |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| arr_addr | output | AW | Array read address |
| arr_data | input | DW | Array read data (combinational) |
| dout | output | DW | Read data |
| dout_valid | output | 1 | High on clocks that carry a burst word |

## Verification
The assertions assume that the configuration changes only while `ce_n` is high. They also assume that every input is stable around the active edge, and that the array returns data for `arr_addr` in the same cycle. The stimulus meets these conditions. It always parks chip enable before a configuration write. It drives all inputs a fixed delay after the active edge in use, and that edge moves to the falling one once the edge-select bit is set. The array is modelled as a pure function of the address.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DATA = 2'd2
    } bsq_state_e;

    localparam int CFG_BURST_BIT = 0;
    localparam int CFG_FALL_BIT  = 1;
    localparam int CFG_LAT_LSB   = 2;

endpackage

// File: rtl/bsq_lat_clamp.sv
module bsq_lat_clamp #(
    parameter int LAT_W   = 4,
    parameter int MIN_LAT = 2
) (
    input  logic [LAT_W-1:0] lat_raw,
    output logic [LAT_W-1:0] wait_load
);
    localparam logic [LAT_W-1:0] MIN_V = LAT_W'(MIN_LAT);

    // Countdown preset is latency minus one: the loading edge is edge 0.
    always_comb begin
        if (lat_raw < MIN_V) begin
            wait_load = MIN_V - 1'b1;
        end else begin
            wait_load = lat_raw - 1'b1;
        end
    end

endmodule

// File: rtl/bsq_core.sv
module bsq_core
    import bsq_pkg::*;
#(
    parameter int AW    = 12,
    parameter int DW    = 16,
    parameter int LAT_W = 4
) (
    input  logic             core_clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             burst_en_i,
    input  logic             adv_n_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [LAT_W-1:0] wait_load_i,
    input  logic [DW-1:0]    arr_data_i,
    output logic [AW-1:0]    ctr_o,
    output logic [DW-1:0]    data_o,
    output logic             vld_o
);

    typedef struct packed {
        bsq_state_e       st;
        logic [LAT_W-1:0] cnt;
        logic [AW-1:0]    ctr;
        logic [DW-1:0]    data;
        logic             vld;
    } core_s;

    core_s cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.vld = 1'b0;
        if (!run_i) begin
            nxt_d.st   = ST_IDLE;
            nxt_d.data = '0;
        end else if (!adv_n_i) begin
            nxt_d.ctr  = addr_i;
            nxt_d.data = '0;
            nxt_d.cnt  = wait_load_i;
            nxt_d.st   = burst_en_i ? ST_WAIT : ST_IDLE;
        end else if (!burst_en_i) begin
            nxt_d.st   = ST_IDLE;
            nxt_d.data = '0;
        end else begin
            unique case (cur_q.st)
                ST_WAIT: begin
                    if (cur_q.cnt == '0) begin
                        nxt_d.data = arr_data_i;
                        nxt_d.vld  = 1'b1;
                        nxt_d.ctr  = cur_q.ctr + 1'b1;
                        nxt_d.st   = ST_DATA;
                    end else begin
                        nxt_d.cnt = cur_q.cnt - 1'b1;
                    end
                end
                ST_DATA: begin
                    nxt_d.data = arr_data_i;
                    nxt_d.vld  = 1'b1;
                    nxt_d.ctr  = cur_q.ctr + 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge core_clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, cnt: '0, ctr: '0, data: '0, vld: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ctr_o  = cur_q.ctr;
    assign data_o = cur_q.data;
    assign vld_o  = cur_q.vld;

    AST_STROBE_LOADS: assert property (@(posedge core_clk) disable iff (!rst_n)
        (run_i && !adv_n_i) |=> (cur_q.ctr == $past(addr_i))); // R2

    AST_FIRST_AFTER_WAIT: assert property (@(posedge core_clk) disable iff (!rst_n)
        $rose(cur_q.vld) |-> ($past(cur_q.st) == ST_WAIT && $past(cur_q.cnt) == '0)); // R3

    AST_MIN_WAIT: assert property (@(posedge core_clk) disable iff (!rst_n)
        (run_i && !adv_n_i && burst_en_i) |=> (cur_q.st == ST_WAIT && cur_q.cnt != '0)); // R4

    AST_LINEAR_STEP: assert property (@(posedge core_clk) disable iff (!rst_n)
        (run_i && adv_n_i && burst_en_i && cur_q.st == ST_DATA)
        |=> (cur_q.ctr == AW'($past(cur_q.ctr) + 1'b1))); // R5

    AST_CE_STOPS: assert property (@(posedge core_clk) disable iff (!rst_n)
        !run_i |=> (!cur_q.vld && cur_q.st == ST_IDLE)); // R9

    AST_RESTART: assert property (@(posedge core_clk) disable iff (!rst_n)
        (run_i && !adv_n_i && cur_q.st == ST_DATA) |=> !cur_q.vld); // R8

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
    import bsq_pkg::*;
#(
    parameter int AW      = 12,
    parameter int DW      = 16,
    parameter int LAT_W   = 4,
    parameter int MIN_LAT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [LAT_W+1:0]   cfg_wdata,
    input  logic               adv_n,
    input  logic [AW-1:0]      addr_in,
    input  logic               ce_n,
    input  logic               oe_n,
    output logic [AW-1:0]      arr_addr,
    input  logic [DW-1:0]      arr_data,
    output logic [DW-1:0]      dout,
    output logic               dout_valid
);

    localparam int CFG_W  = LAT_W + 2;
    localparam int N_EDGE = 2;

    logic [CFG_W-1:0] cfg_q, cfg_d;
    logic             burst_en;
    logic             sel;
    logic [LAT_W-1:0] lat_raw;
    logic [LAT_W-1:0] wait_load;
    logic             clk_n;
    logic             edge_clk [N_EDGE];
    logic [AW-1:0]    core_ctr [N_EDGE];
    logic [DW-1:0]    core_data[N_EDGE];
    logic             core_vld [N_EDGE];

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign burst_en = cfg_q[CFG_BURST_BIT];
    assign sel      = cfg_q[CFG_FALL_BIT];
    assign lat_raw  = cfg_q[CFG_LAT_LSB +: LAT_W];
    assign clk_n    = ~clk;
    assign edge_clk[0] = clk;
    assign edge_clk[1] = clk_n;

    bsq_lat_clamp #(
        .LAT_W   (LAT_W),
        .MIN_LAT (MIN_LAT)
    ) u_clamp (
        .lat_raw   (lat_raw),
        .wait_load (wait_load)
    );

    for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
        logic run;
        assign run = !ce_n && (32'(sel) == e);

        bsq_core #(
            .AW    (AW),
            .DW    (DW),
            .LAT_W (LAT_W)
        ) u_core (
            .core_clk    (edge_clk[e]),
            .rst_n       (rst_n),
            .run_i       (run),
            .burst_en_i  (burst_en),
            .adv_n_i     (adv_n),
            .addr_i      (addr_in),
            .wait_load_i (wait_load),
            .arr_data_i  (arr_data),
            .ctr_o       (core_ctr[e]),
            .data_o      (core_data[e]),
            .vld_o       (core_vld[e])
        );
    end

    assign arr_addr   = core_ctr[sel];
    assign dout_valid = !ce_n && !oe_n && core_vld[sel];

    always_comb begin
        if (ce_n || oe_n) begin
            dout = '0;
        end else if (burst_en) begin
            dout = core_data[sel];
        end else begin
            dout = arr_data;
        end
    end

    AST_ASYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_en && $past(!burst_en)) |=> !dout_valid); // R7

    AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (dout == '0)); // R10

endmodule

// File: tb/burst_rd_seq_tb.sv
module burst_rd_seq_tb;

    localparam int AW = 12;
    localparam int DW = 16;

    typedef struct {
        logic          v;
        logic [DW-1:0] d;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_wdata = '0;
    logic          adv_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          ce_n = 1'b0;
    logic          oe_n = 1'b0;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_data;
    logic [DW-1:0] dout;
    logic          dout_valid;

    int   total = 0;
    int   bad = 0;
    bit   fall_mode = 1'b0;
    exp_t sb[$];
    event smp;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return ({4'h0, a} * 16'd37) ^ 16'h5A3C;
    endfunction

    assign arr_data = mem_word(arr_addr);

    burst_rd_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .adv_n      (adv_n),
        .addr_in    (addr_in),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .arr_addr   (arr_addr),
        .arr_data   (arr_data),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    // monitor: pops one expectation per sample point and compares
    initial begin
        forever begin
            @(smp);
            #1;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL scoreboard empty at sample");
            end else begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (dout_valid !== e.v || dout !== e.d) begin
                    bad++;
                    $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                             e.req, dout_valid, dout, e.v, e.d);
                end
            end
        end
    end

    // driver: waits for the active edge, queues the expectation, releases inputs
    task automatic tick(input logic ev, input logic [DW-1:0] ed, input string req);
        exp_t e;
        if (fall_mode) @(negedge clk);
        else           @(posedge clk);
        #4;
        e.v = ev; e.d = ed; e.req = req;
        sb.push_back(e);
        -> smp;
        #2;
    endtask

    task automatic cfg_write(input logic [3:0] lat, input logic fall, input logic burst);
        cfg_we    = 1'b1;
        cfg_wdata = {lat, fall, burst};
        tick(1'b0, '0, "R1");
        cfg_we    = 1'b0;
    endtask

    task automatic burst(input logic [AW-1:0] start, input int lat, input int n, input string tag);
        adv_n   = 1'b0;
        addr_in = start;
        tick(1'b0, '0, tag);
        adv_n   = 1'b1;
        addr_in = ~start;
        for (int k = 1; k < lat + n; k++) begin
            if (k < lat) tick(1'b0, '0, tag);
            else if (k == lat) tick(1'b1, mem_word(start), "R2");
            else tick(1'b1, mem_word(AW'(start + AW'(k - lat))), "R5");
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #25 rst_n = 1'b1;
        // R1: reset state, burst off, counter at zero
        tick(1'b0, mem_word('0), "R1");
        // R7: asynchronous read of a latched address
        adv_n = 1'b0; addr_in = 12'h123;
        tick(1'b0, mem_word(12'h123), "R7");
        adv_n = 1'b1; addr_in = 12'h777;
        tick(1'b0, mem_word(12'h123), "R7");
        oe_n = 1'b1;
        tick(1'b0, '0, "R10");
        oe_n = 1'b0;

        // enable burst, latency 4, rising edge
        ce_n = 1'b1;
        cfg_write(4'd4, 1'b0, 1'b1);
        ce_n = 1'b0;
        burst(12'h010, 4, 5, "R3");

        // R9: chip enable stops the stream, no resume
        ce_n = 1'b1;
        tick(1'b0, '0, "R9");
        ce_n = 1'b0;
        tick(1'b0, '0, "R9");
        tick(1'b0, '0, "R9");

        // R4: clamp of latency 0 and 1
        ce_n = 1'b1;
        cfg_write(4'd0, 1'b0, 1'b1);
        ce_n = 1'b0;
        burst(12'h200, 2, 3, "R4");
        ce_n = 1'b1;
        cfg_write(4'd1, 1'b0, 1'b1);
        ce_n = 1'b0;
        burst(12'h2A0, 2, 2, "R4");

        // R3: longest latency
        ce_n = 1'b1;
        cfg_write(4'd15, 1'b0, 1'b1);
        ce_n = 1'b0;
        burst(12'h050, 15, 2, "R3");

        // R5: wrap through all-ones, latency 3
        ce_n = 1'b1;
        cfg_write(4'd3, 1'b0, 1'b1);
        ce_n = 1'b0;
        burst(12'hFFE, 3, 4, "R5");

        // R8: new strobe mid-stream restarts
        burst(12'h300, 3, 3, "R8");
        burst(12'h400, 3, 3, "R8");

        // R10: output gated off while counting continues
        ce_n = 1'b1;
        cfg_write(4'd2, 1'b0, 1'b1);
        ce_n = 1'b0;
        burst(12'h500, 2, 1, "R10");
        oe_n = 1'b1;
        tick(1'b0, '0, "R10");
        tick(1'b0, '0, "R10");
        oe_n = 1'b0;
        tick(1'b1, mem_word(12'h503), "R10");

        // R6: falling edge operation
        ce_n = 1'b1;
        cfg_write(4'd3, 1'b1, 1'b1);
        fall_mode = 1'b1;
        ce_n = 1'b0;
        burst(12'h600, 3, 4, "R6");

        // back to burst off on the rising edge
        ce_n = 1'b1;
        cfg_write(4'd3, 1'b0, 1'b0);
        fall_mode = 1'b0;
        tick(1'b0, '0, "R9");
        ce_n = 1'b0;
        adv_n = 1'b0; addr_in = 12'hABC;
        tick(1'b0, mem_word(12'hABC), "R7");
        adv_n = 1'b1;
        tick(1'b0, mem_word(12'hABC), "R7");

        #10;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL scoreboard left %0d items", sb.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule